// File: doc/BRIEF.md
# Receive Mailbox Match Scanner

This block chooses which receive mailbox takes a newly arrived frame. Once the frame sits in the serial holding buffer, a start pulse launches one sweep over the mailbox array. The sweep looks at one mailbox per clock in rising index order and compares each mailbox's programmed identifier with the identifier of the frame. A mailbox that is empty and matches is preferred. If no empty mailbox matches, a matching mailbox that already holds a frame is chosen and will be overwritten.

Host writes can deactivate a mailbox while a sweep is running. The sweep never goes back. A deactivated mailbox that has not yet been visited is skipped when the sweep reaches it. If the current pick is deactivated, the pick is dropped and only mailboxes not yet visited can replace it. When nothing replaces it, the frame is reported lost, even if an earlier mailbox could have taken it. At the end of the sweep the block gives a one-cycle done pulse, together with either a found flag and a mailbox index or a lost flag.

Copying the frame data, acceptance masking, queue-style reception and the bus bit engine belong to other blocks.

Top module: `rxm_scanner`

## Requirements
- R1: While reset is asserted and after it is released, `done_o`, `found_o` and `lost_o` are low until a sweep completes.
- R2: A `start_i` sampled high while idle starts a sweep of mailboxes 0 to N_MB-1, one per clock. `done_o` is high for exactly one cycle: the cycle that follows the N_MB-th rising edge after the start edge.
- R3: `start_i` is ignored while a sweep is running. The sweep is never restarted and gives exactly one done pulse.
- R4: A mailbox can match only if all three hold: its enable bit in `mb_active_i` is 1, its 4-bit code is not 4'b0000 (inactive), and its identifier equals the frame identifier captured at start.
- R5: A matching mailbox with code 4'b0100 is free. If any free mailbox still qualifies at the end of the sweep, the lowest-index one is reported through `found_o` and `idx_o`.
- R6: If no free mailbox qualifies, the lowest-index matching mailbox with any other non-inactive code (full) is reported as found, to be overwritten.
- R7: If nothing qualifies at the end of the sweep, `lost_o` pulses with `done_o` and `found_o` stays low.
- R8: If bit j of `deact_i` is high on the edge where mailbox j is visited, or on any earlier edge of the same sweep, mailbox j is excluded.
- R9: If `deact_i` strikes the current pick after it was visited, the pick is dropped. Only mailboxes not yet visited can replace it. If none does, the frame is lost.
- R10: `deact_i` pulses seen while idle have no effect on the next sweep.
- R11: `found_o` and `lost_o` are high only together with `done_o`, and exactly one of them is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame-ready pulse that launches a sweep |
| rx_id_i | input | ID_W | Identifier of the received frame, captured at start |
| mb_id_i | input | N_MB*ID_W | Packed mailbox identifiers; mailbox k in bits [k*ID_W +: ID_W] |
| mb_code_i | input | N_MB*4 | Packed mailbox codes; mailbox k in bits [k*4 +: 4] |
| mb_active_i | input | N_MB | Per-mailbox enable |
| deact_i | input | N_MB | Per-mailbox deactivation strobe from host writes |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |
| found_o | output | 1 | A mailbox was selected (valid with done_o) |
| lost_o | output | 1 | No mailbox could take the frame (valid with done_o) |
| idx_o | output | CNT_W | Index of the selected mailbox |

## Verification
The assertions assume that mailbox identifiers, codes and enables hold steady for the length of a sweep, and that `deact_i` is the only input allowed to change them while a sweep is running. They also assume `deact_i` is a short strobe, not a level. The bench drives a mailbox setup before each start pulse and leaves it unchanged until the done pulse. Mid-sweep changes are limited to single-cycle `deact_i` pulses on chosen visit steps, and to one stray `start_i` pulse that checks the sweep is not restarted.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_INACTIVE = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_EMPTY    = 4'b0100;

  typedef enum logic {ST_IDLE, ST_SCAN} scan_state_e;
endpackage

// File: rtl/rxm_visit.sv
module rxm_visit
  import rxm_pkg::*;
#(
  parameter int unsigned N_MB  = 16,
  parameter int unsigned ID_W  = 11,
  parameter int unsigned CNT_W = $clog2(N_MB)
) (
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [ID_W-1:0]        rx_id_i,
  input  logic [N_MB*ID_W-1:0]   mb_id_i,
  input  logic [N_MB*CODE_W-1:0] mb_code_i,
  input  logic [N_MB-1:0]        mb_active_i,
  input  logic [N_MB-1:0]        dead_i,
  output logic                   hit_free_o,
  output logic                   hit_full_o
);
  logic [ID_W-1:0]   cur_id;
  logic [CODE_W-1:0] cur_code;
  logic              eligible;

  always_comb begin
    cur_id   = mb_id_i[cnt_i*ID_W +: ID_W];
    cur_code = mb_code_i[cnt_i*CODE_W +: CODE_W];
    eligible = mb_active_i[cnt_i] && !dead_i[cnt_i] &&
               (cur_code != CODE_INACTIVE) && (cur_id == rx_id_i);
    hit_free_o = eligible && (cur_code == CODE_EMPTY);
    hit_full_o = eligible && (cur_code != CODE_EMPTY);
  end
endmodule

// File: rtl/rxm_cand.sv
module rxm_cand #(
  parameter int unsigned N_MB  = 16,
  parameter int unsigned CNT_W = $clog2(N_MB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             scan_i,
  input  logic [N_MB-1:0]  deact_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] take_idx_i,
  output logic             valid_q_o,
  output logic [CNT_W-1:0] idx_q_o,
  output logic             valid_d_o,
  output logic [CNT_W-1:0] idx_d_o
);
  logic             valid_q;
  logic [CNT_W-1:0] idx_q;
  logic             keep;

  // current pick survives unless struck by deactivation this cycle
  always_comb begin
    keep      = valid_q && !(scan_i && deact_i[idx_q]);
    valid_d_o = keep;
    idx_d_o   = idx_q;
    if (scan_i && !keep && take_i) begin
      valid_d_o = 1'b1;
      idx_d_o   = take_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (scan_i) begin
      valid_q <= valid_d_o;
      idx_q   <= idx_d_o;
    end
  end

  assign valid_q_o = valid_q;
  assign idx_q_o   = idx_q;

  // R9: a struck pick is never kept
  a_r9_struck_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i && !clear_i && valid_q && deact_i[idx_q]) |=>
      (!valid_q || idx_q != $past(idx_q)));

  // R5/R6: an unstruck pick is never displaced by a later visit
  a_r5_keep_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_i && !clear_i && valid_q && !deact_i[idx_q]) |=>
      (valid_q && idx_q == $past(idx_q)));
endmodule

// File: rtl/rxm_scanner.sv
module rxm_scanner
  import rxm_pkg::*;
#(
  parameter int unsigned N_MB  = 16,
  parameter int unsigned ID_W  = 11,
  parameter int unsigned CNT_W = $clog2(N_MB)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [ID_W-1:0]        rx_id_i,
  input  logic [N_MB*ID_W-1:0]   mb_id_i,
  input  logic [N_MB*CODE_W-1:0] mb_code_i,
  input  logic [N_MB-1:0]        mb_active_i,
  input  logic [N_MB-1:0]        deact_i,
  output logic                   done_o,
  output logic                   found_o,
  output logic                   lost_o,
  output logic [CNT_W-1:0]       idx_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_MB - 1);

  scan_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0]  rx_id_q;
  logic [N_MB-1:0]  dead_q;
  logic             done_q, found_q, lost_q;
  logic [CNT_W-1:0] idx_q;

  logic scan, last, go;
  logic hit_free, hit_full;
  logic fr_v_q, fr_v_d, fl_v_q, fl_v_d;
  logic [CNT_W-1:0] fr_i_q, fr_i_d, fl_i_q, fl_i_d;

  assign scan = (state_q == ST_SCAN);
  assign last = (cnt_q == LAST_IDX);
  assign go   = (state_q == ST_IDLE) && start_i;

  rxm_visit #(.N_MB(N_MB), .ID_W(ID_W), .CNT_W(CNT_W)) u_visit (
    .cnt_i       (cnt_q),
    .rx_id_i     (rx_id_q),
    .mb_id_i     (mb_id_i),
    .mb_code_i   (mb_code_i),
    .mb_active_i (mb_active_i),
    .dead_i      (dead_q | deact_i),
    .hit_free_o  (hit_free),
    .hit_full_o  (hit_full)
  );

  rxm_cand #(.N_MB(N_MB), .CNT_W(CNT_W)) u_cand_free (
    .clk_i, .rst_ni,
    .clear_i    (go),
    .scan_i     (scan),
    .deact_i    (deact_i),
    .take_i     (hit_free),
    .take_idx_i (cnt_q),
    .valid_q_o  (fr_v_q),
    .idx_q_o    (fr_i_q),
    .valid_d_o  (fr_v_d),
    .idx_d_o    (fr_i_d)
  );

  rxm_cand #(.N_MB(N_MB), .CNT_W(CNT_W)) u_cand_full (
    .clk_i, .rst_ni,
    .clear_i    (go),
    .scan_i     (scan),
    .deact_i    (deact_i),
    .take_i     (hit_full),
    .take_idx_i (cnt_q),
    .valid_q_o  (fl_v_q),
    .idx_q_o    (fl_i_q),
    .valid_d_o  (fl_v_d),
    .idx_d_o    (fl_i_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_id_q <= '0;
      dead_q  <= '0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      lost_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      found_q <= 1'b0;
      lost_q  <= 1'b0;
      if (go) begin
        state_q <= ST_SCAN;
        cnt_q   <= '0;
        rx_id_q <= rx_id_i;
        dead_q  <= '0;
      end else if (scan) begin
        dead_q <= dead_q | deact_i;
        cnt_q  <= cnt_q + 1'b1;
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          found_q <= fr_v_d || fl_v_d;
          lost_q  <= !(fr_v_d || fl_v_d);
          idx_q   <= fr_v_d ? fr_i_d : fl_i_d;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign found_o = found_q;
  assign lost_o  = lost_q;
  assign idx_o   = idx_q;

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(scan && last));

  a_r3_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan && !last) |=> (scan && cnt_q == $past(cnt_q) + 1'b1));

  a_r11_flags_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (found_o || lost_o) |-> done_o);

  a_r11_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (found_o != lost_o));

  a_r5_free_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan && last && fr_v_q && !deact_i[fr_i_q]) |=> (found_o && idx_o == $past(fr_i_q)));
endmodule

// File: tb/rxm_scanner_bench.sv
module rxm_scanner_bench;
  localparam int N = 16;
  localparam int IW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] rx_id = '0;
  logic [N*IW-1:0] mb_id_f;
  logic [N*4-1:0] mb_code_f;
  logic [N-1:0] mb_act;
  logic [N-1:0] deact = '0;
  logic done, found, lost;
  logic [3:0] idx;

  int id_a[N];
  int code_a[N];
  int checks = 0;
  int errors = 0;

  int   q_idx[$];
  bit   q_found[$];
  string q_req[$];

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      mb_id_f[k*IW +: IW] = IW'(id_a[k]);
      mb_code_f[k*4 +: 4] = 4'(code_a[k]);
    end
  end

  rxm_scanner u_rxm_scanner (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_id_i(rx_id),
    .mb_id_i(mb_id_f), .mb_code_i(mb_code_f), .mb_active_i(mb_act),
    .deact_i(deact), .done_o(done), .found_o(found), .lost_o(lost), .idx_o(idx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic setup_default();
    for (int k = 0; k < N; k++) begin
      id_a[k] = 'h100 + k;
      code_a[k] = 4'b0010;
    end
    mb_act = '1;
  endtask

  // reference: one forward pass, struck picks dropped, free preferred
  task automatic predict(input int rx, input int dstep, input int dmb,
                         output bit f, output int ix);
    bit dead[N];
    bit fv = 0, uv = 0;
    int fi = 0, ui = 0;
    for (int k = 0; k < N; k++) dead[k] = 0;
    for (int v = 0; v < N; v++) begin
      if (v == dstep) begin
        dead[dmb] = 1;
        if (fv && fi == dmb) fv = 0;
        if (uv && ui == dmb) uv = 0;
      end
      if (!dead[v] && mb_act[v] && code_a[v] != 0 && id_a[v] == rx) begin
        if (code_a[v] == 4 && !fv) begin fv = 1; fi = v; end
        else if (code_a[v] != 4 && !uv) begin uv = 1; ui = v; end
      end
    end
    f = fv || uv;
    ix = fv ? fi : (uv ? ui : 0);
  endtask

  task automatic run_scan(input int rx, input int dstep, input int dmb,
                          input int mid_start, input string req);
    bit f;
    int ix;
    int lat = -1;
    predict(rx, dstep, dmb, f, ix);
    q_found.push_back(f);
    q_idx.push_back(ix);
    q_req.push_back(req);
    @(negedge clk);
    rx_id = IW'(rx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < N + 4; s++) begin
      deact = (s == dstep) ? (N'(1) << dmb) : '0;
      start = (s == mid_start);
      @(negedge clk);
      if (done && lat < 0) lat = s + 1;
    end
    deact = '0;
    start = 1'b0;
    chk(lat == N, "R2 done latency", lat, N);
  endtask

  // monitor: pops scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_found.size() == 0) begin
        chk(0, "R3 unexpected done", 1, 0);
      end else begin
        bit ef;
        int ei;
        string rq;
        ef = q_found.pop_front();
        ei = q_idx.pop_front();
        rq = q_req.pop_front();
        chk(found == ef, {rq, " found"}, found, ef);
        chk(lost == !ef, {rq, " R7/R11 lost"}, lost, !ef);
        if (ef) chk(idx == 4'(ei), {rq, " idx"}, idx, ei);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    setup_default();
    repeat (3) @(negedge clk);
    chk(!done && !found && !lost, "R1 in reset", {done, found, lost}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !found && !lost, "R1 after reset", {done, found, lost}, 0);

    // R5 single free match
    setup_default(); id_a[7] = 'h55; code_a[7] = 4;
    run_scan('h55, -1, 0, -1, "R5 single");
    // R5 two free, one full lower: free lowest wins
    setup_default(); id_a[3] = 'h55; code_a[3] = 4; id_a[9] = 'h55; code_a[9] = 4;
    id_a[1] = 'h55;
    run_scan('h55, -1, 0, -1, "R5 lowest free");
    // R6 only full matches
    setup_default(); id_a[2] = 'h55; id_a[10] = 'h55;
    run_scan('h55, -1, 0, -1, "R6 overwrite");
    // R7 no match
    setup_default();
    run_scan('h55, -1, 0, -1, "R7 none");
    // R4 inactive code and disabled mailbox excluded
    setup_default(); id_a[4] = 'h55; code_a[4] = 0; id_a[6] = 'h55; code_a[6] = 4;
    mb_act[6] = 1'b0;
    run_scan('h55, -1, 0, -1, "R4 ineligible");
    setup_default(); id_a[4] = 'h55; code_a[4] = 0; id_a[12] = 'h55; code_a[12] = 4;
    run_scan('h55, -1, 0, -1, "R4 skip inactive");
    // R8 unvisited candidate struck early
    setup_default(); id_a[3] = 'h55; code_a[3] = 4; id_a[9] = 'h55; code_a[9] = 4;
    run_scan('h55, 1, 3, -1, "R8 early strike");
    // R8 struck on its own visit
    run_scan('h55, 9, 9, -1, "R8 same-edge strike");
    // R9 visited pick struck, later one takes it
    run_scan('h55, 5, 3, -1, "R9 refind");
    // R9 pick struck after second match passed: lost
    setup_default(); id_a[2] = 'h55; code_a[2] = 4; id_a[5] = 'h55; code_a[5] = 4;
    run_scan('h55, 7, 2, -1, "R9 lost");
    // R9 struck full pick falls back to nothing later
    setup_default(); id_a[1] = 'h55; id_a[14] = 'h55;
    run_scan('h55, 15, 1, -1, "R9 full struck");
    // R3 stray start mid-sweep
    setup_default(); id_a[8] = 'h2A; code_a[8] = 4;
    run_scan('h2A, -1, 0, 5, "R3 stray start");
    // R10 strike while idle has no effect
    setup_default(); id_a[3] = 'h55; code_a[3] = 4;
    @(negedge clk); deact = N'(1) << 3;
    @(negedge clk); deact = '0;
    run_scan('h55, -1, 0, -1, "R10 idle strike");
    // last index and back-to-back
    setup_default(); id_a[15] = 'h7FF; code_a[15] = 4;
    run_scan('h7FF, -1, 0, -1, "R5 last index");
    run_scan('h7FF, -1, 0, -1, "R2 back to back");

    repeat (4) @(negedge clk);
    chk(q_found.size() == 0, "R3 pending results", q_found.size(), 0);
    summary();
    $finish;
  end
endmodule